// File: doc/BRIEF.md
# Single-Wire Bus Handoff Controller

This block sits beside a processor's bus interface and lets other local masters borrow the local bus. Each other master owns one open-drain, active-low line, and the block serves two such lines by default. Request, grant and release all travel on the same wire as one-clock low pulses. The other master pulses the line to ask for the bus. The block answers with one grant pulse at a safe point in the processor's bus cycle. It then floats its bus drivers by raising hold-acknowledge until the other master pulses the line again to hand the bus back.

The block does not generate bus cycles. It observes them through a two-bit T-state code, a cycle-active flag and three qualifiers: odd-address split word, first interrupt acknowledge and locked instruction. From these it decides when the bus may be released. A stall output holds off new processor cycles from the grant clock until the bus is safely reclaimed. A debug flag marks pulses that arrive when no pulse is expected.

Top module: `rg_handoff_ctrl`

## Requirements
- R1: While reset is held, and after it is released, no line is driven, hold-acknowledge is low, stall is low and the debug flag is low.
- R2: If a low is sampled on a line while no cycle is active and no lock is held, the grant pulse is driven on that line in the very next clock, and hold-acknowledge is high from the clock after the grant.
- R3: A request sampled in T1 or T2 of an active cycle (tstate code 0 or 1) is granted in the clock that follows the T4 clock (tstate code 3) of that same cycle.
- R4: A request first sampled in T3 or T4 (code 2 or 3) of an active cycle is not granted at that cycle's T4. It is granted after the T4 of the next cycle, or on an idle clock.
- R5: While the odd-address split flag or the first-interrupt-acknowledge flag is high at T4, the request stays pending. It is granted after the first later T4 at which both flags are low.
- R6: While the lock input is high, no grant is issued, neither on idle clocks nor at T4. A pending request is granted on the first clock after lock is sampled low at a release point.
- R7: Hold-acknowledge stays high until a low is sampled on the granted line. In the following clock hold-acknowledge is low and stall stays high for that one dead clock. A request sampled during the dead clock is not granted.
- R8: When both lines are sampled low together from idle, only line 0 is granted. At most one line is ever driven at a time.
- R9: A grant drives the line low (output level 0 with output enable 1) for exactly one clock. At all other times the output enable is 0.
- R10: A low sampled on a line while pending, granting, holding on a different line, or in the dead clock changes nothing at the outputs except the debug flag, which is high for the one clock after the sample.
- R11: Stall is high in the grant clock, throughout hold-acknowledge and in the dead clock, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cyc_active | input | 1 | A processor bus cycle is in progress |
| tstate | input | 2 | Current T-state: 0=T1, 1=T2, 2=T3 (including waits), 3=T4 |
| odd_lo_split | input | 1 | Current cycle is the low byte of a word on an odd address |
| inta_first | input | 1 | Current cycle is the first interrupt acknowledge |
| lock_on | input | 1 | A locked instruction is executing |
| line_in | input | NLINES | Sampled level of each request/grant line (low = pulse) |
| line_out | output | NLINES | Level driven on each line when enabled (always low) |
| line_oe | output | NLINES | Output enable for each line, one-hot during a grant |
| hlda | output | 1 | Hold-acknowledge: bus drivers, status and lock outputs float |
| stall | output | 1 | Hold off new processor bus cycles |
| stray_flag | output | 1 | Debug: an unexpected pulse was ignored |

## Verification
The grant point is tried with requests landing in each T-state of an active cycle and on idle clocks. This separates an early request, granted at the same cycle's T4, from a late one that must wait for the next cycle. Split-word, interrupt-acknowledge and lock qualifiers are each held across one or more T4 clocks and then dropped, which shows that the request stays pending and is taken at the first clean point. Simultaneous requests and pulses on the wrong line during pending, hold and dead clocks show that priority holds and that stray pulses move only the debug flag.

// File: rtl/rg_handoff_pkg.sv
package rg_handoff_pkg;
  typedef enum logic [2:0] {
    RG_IDLE  = 3'd0,
    RG_PEND  = 3'd1,
    RG_GRANT = 3'd2,
    RG_HOLD  = 3'd3,
    RG_DEAD  = 3'd4
  } rg_state_e;

  localparam logic [1:0] TS_T1 = 2'd0;
  localparam logic [1:0] TS_T2 = 2'd1;
  localparam logic [1:0] TS_T3 = 2'd2;
  localparam logic [1:0] TS_T4 = 2'd3;
endpackage

// File: rtl/rg_pick.sv
// Fixed-priority picker: lowest-numbered active request wins.
module rg_pick #(
  parameter int NLINES = 2,
  parameter int IW     = 1
) (
  input  logic [NLINES-1:0] req,
  output logic              vld,
  output logic [IW-1:0]     idx
);
  always_comb begin
    vld = 1'b0;
    idx = '0;
    for (int i = NLINES - 1; i >= 0; i--) begin
      if (req[i]) begin
        vld = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/rg_gate.sv
// Decides whether the bus may be handed over in the current clock.
module rg_gate
  import rg_handoff_pkg::*;
(
  input  logic       cyc_active,
  input  logic [1:0] tstate,
  input  logic       odd_lo_split,
  input  logic       inta_first,
  input  logic       lock_on,
  input  logic       late_q,
  output logic       may_rel
);
  logic at_t4_ok;

  always_comb begin
    at_t4_ok = (tstate == TS_T4) && !late_q && !odd_lo_split && !inta_first;
    may_rel  = !lock_on && (!cyc_active || at_t4_ok);
  end
endmodule

// File: rtl/rg_pins.sv
// Per-line open-drain drive: enable only on the granted line in the grant clock.
module rg_pins #(
  parameter int NLINES = 2,
  parameter int IW     = 1
) (
  input  logic              grant_en,
  input  logic [IW-1:0]     own,
  output logic [NLINES-1:0] oe,
  output logic [NLINES-1:0] lvl
);
  for (genvar g = 0; g < NLINES; g++) begin : g_line
    assign oe[g]  = grant_en && (own == IW'(g));
    assign lvl[g] = 1'b0;
  end
endmodule

// File: rtl/rg_handoff_ctrl.sv
module rg_handoff_ctrl
  import rg_handoff_pkg::*;
#(
  parameter int NLINES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_active,
  input  logic [1:0]        tstate,
  input  logic              odd_lo_split,
  input  logic              inta_first,
  input  logic              lock_on,
  input  logic [NLINES-1:0] line_in,
  output logic [NLINES-1:0] line_out,
  output logic [NLINES-1:0] line_oe,
  output logic              hlda,
  output logic              stall,
  output logic              stray_flag
);
  localparam int IW = (NLINES > 1) ? $clog2(NLINES) : 1;

  rg_state_e         st_q, st_d;
  logic [IW-1:0]     own_q, own_d;
  logic              late_q, late_d;
  logic              stray_q, stray_d;
  logic [NLINES-1:0] lows;
  logic [NLINES-1:0] own_mask;
  logic              pick_vld;
  logic [IW-1:0]     pick_idx;
  logic              may_rel;
  logic              late_arrival;

  assign lows     = ~line_in;
  assign own_mask = NLINES'(1) << own_q;

  rg_pick #(.NLINES(NLINES), .IW(IW)) u_pick (
    .req (lows),
    .vld (pick_vld),
    .idx (pick_idx)
  );

  rg_gate u_gate (
    .cyc_active   (cyc_active),
    .tstate       (tstate),
    .odd_lo_split (odd_lo_split),
    .inta_first   (inta_first),
    .lock_on      (lock_on),
    .late_q       (late_q),
    .may_rel      (may_rel)
  );

  assign late_arrival = cyc_active && ((tstate == TS_T3) || (tstate == TS_T4));

  // next-state process
  always_comb begin
    st_d    = st_q;
    own_d   = own_q;
    late_d  = late_q;
    stray_d = 1'b0;
    case (st_q)
      RG_IDLE: begin
        if (pick_vld) begin
          own_d = pick_idx;
          if (!lock_on && !cyc_active) begin
            st_d   = RG_GRANT;
            late_d = 1'b0;
          end else begin
            st_d   = RG_PEND;
            late_d = late_arrival;
          end
        end
      end
      RG_PEND: begin
        stray_d = |lows;
        if (may_rel) begin
          st_d   = RG_GRANT;
          late_d = 1'b0;
        end else if (!cyc_active || (tstate == TS_T1)) begin
          late_d = 1'b0;
        end
      end
      RG_GRANT: begin
        stray_d = |(lows & ~own_mask);
        st_d    = RG_HOLD;
      end
      RG_HOLD: begin
        stray_d = |(lows & ~own_mask);
        if (|(lows & own_mask)) begin
          st_d = RG_DEAD;
        end
      end
      RG_DEAD: begin
        stray_d = |lows;
        st_d    = RG_IDLE;
      end
      default: st_d = RG_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RG_IDLE;
      own_q   <= '0;
      late_q  <= 1'b0;
      stray_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      stray_q <= stray_d;
      if (st_d != st_q) begin
        own_q <= own_d;
      end
      late_q <= late_d;
    end
  end

  rg_pins #(.NLINES(NLINES), .IW(IW)) u_pins (
    .grant_en (st_q == RG_GRANT),
    .own      (own_q),
    .oe       (line_oe),
    .lvl      (line_out)
  );

  assign hlda       = (st_q == RG_HOLD);
  assign stall      = (st_q == RG_GRANT) || (st_q == RG_HOLD) || (st_q == RG_DEAD);
  assign stray_flag = stray_q;
endmodule

// File: rtl/rg_handoff_ctrl_chk.sv
module rg_handoff_ctrl_chk #(
  parameter int NLINES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cyc_active,
  input logic [1:0]        tstate,
  input logic              lock_on,
  input logic [NLINES-1:0] line_oe,
  input logic              hlda,
  input logic              stall
);
  p_onehot_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(line_oe));

  p_grant_one_clock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|line_oe) |=> !(|line_oe));

  p_hold_follows_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|line_oe) |=> hlda);

  p_grant_only_after_t4_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((|line_oe) && $past(cyc_active)) |-> ($past(tstate) == 2'd3));

  p_no_grant_under_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|line_oe) |-> !$past(lock_on));

  p_stall_covers_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((|line_oe) || hlda) |-> stall);

  p_single_dead_clock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hlda) |-> (stall && !(|line_oe)));

  p_dead_then_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hlda) |=> !stall);
endmodule

bind rg_handoff_ctrl rg_handoff_ctrl_chk #(.NLINES(NLINES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cyc_active (cyc_active),
  .tstate     (tstate),
  .lock_on    (lock_on),
  .line_oe    (line_oe),
  .hlda       (hlda),
  .stall      (stall)
);

// File: tb/rg_handoff_ctrl_test.sv
module rg_handoff_ctrl_test;
  localparam logic [1:0] T1 = 2'd0;
  localparam logic [1:0] T2 = 2'd1;
  localparam logic [1:0] T3 = 2'd2;
  localparam logic [1:0] T4 = 2'd3;

  logic       clk;
  logic       rst_n;
  logic       cyc_active;
  logic [1:0] tstate;
  logic       odd_lo_split;
  logic       inta_first;
  logic       lock_on;
  logic [1:0] ext_n;
  logic [1:0] pin_n;
  logic [1:0] line_out;
  logic [1:0] line_oe;
  logic       hlda;
  logic       stall;
  logic       stray_flag;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  typedef struct packed {
    logic [1:0] drv;
    logic       hl;
    logic       st;
    logic       fl;
  } exp_t;

  exp_t  expq[$];
  string tagq[$];

  // wired-AND line model: block pulls low when enabled, else other master or pull-up
  assign pin_n = ext_n & ~(line_oe & ~line_out);

  rg_handoff_ctrl #(.NLINES(2)) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cyc_active   (cyc_active),
    .tstate       (tstate),
    .odd_lo_split (odd_lo_split),
    .inta_first   (inta_first),
    .lock_on      (lock_on),
    .line_in      (pin_n),
    .line_out     (line_out),
    .line_oe      (line_oe),
    .hlda         (hlda),
    .stall        (stall),
    .stray_flag   (stray_flag)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input exp_t act, input exp_t exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at %0t: actual drv=%b hlda=%b stall=%b flag=%b expected drv=%b hlda=%b stall=%b flag=%b",
               tag, $time, act.drv, act.hl, act.st, act.fl, exp.drv, exp.hl, exp.st, exp.fl);
    end
  endtask

  function automatic exp_t now_out();
    exp_t o;
    o.drv = line_oe & ~line_out;
    o.hl  = hlda;
    o.st  = stall;
    o.fl  = stray_flag;
    return o;
  endfunction

  // driver: sets inputs for the coming edge and queues the outputs expected after it
  task automatic tick(input logic [1:0] ext, input logic act, input logic [1:0] ts,
                      input logic sp, input logic ia, input logic lk,
                      input logic [1:0] edrv, input logic eh, input logic es, input logic ef,
                      input string tag);
    exp_t e;
    @(negedge clk);
    ext_n        = ext;
    cyc_active   = act;
    tstate       = ts;
    odd_lo_split = sp;
    inta_first   = ia;
    lock_on      = lk;
    e.drv = edrv;
    e.hl  = eh;
    e.st  = es;
    e.fl  = ef;
    expq.push_back(e);
    tagq.push_back(tag);
  endtask

  // monitor: compares after each edge, once outputs have settled
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expq.size() > 0) begin
        exp_t  e;
        exp_t  a;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        a = now_out();
        check(a == e, t, a, e);
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    exp_t z;
    z = '0;
    rst_n        = 1'b0;
    ext_n        = 2'b11;
    cyc_active   = 1'b0;
    tstate       = T1;
    odd_lo_split = 1'b0;
    inta_first   = 1'b0;
    lock_on      = 1'b0;
    repeat (3) @(negedge clk);
    check(now_out() == z, "R1 in reset", now_out(), z);
    rst_n = 1'b1;
    @(negedge clk);
    check(now_out() == z, "R1 after reset", now_out(), z);

    // idle request on line 0, hold, release, dead clock
    tick(2'b10, 0, T1, 0, 0, 0, 2'b01, 0, 1, 0, "R2 idle grant");
    tick(2'b11, 0, T1, 0, 0, 0, 2'b00, 1, 1, 0, "R9 grant one clock");
    tick(2'b11, 0, T1, 0, 0, 0, 2'b00, 1, 1, 0, "R7 hold kept");
    tick(2'b10, 0, T1, 0, 0, 0, 2'b00, 0, 1, 0, "R7 release dead clock");
    tick(2'b10, 0, T1, 0, 0, 0, 2'b00, 0, 0, 1, "R10 pulse in dead clock");
    tick(2'b11, 0, T1, 0, 0, 0, 2'b00, 0, 0, 0, "R7 dead request ignored");

    // early request in active cycle
    tick(2'b10, 1, T1, 0, 0, 0, 2'b00, 0, 0, 0, "R3 pending at T1");
    tick(2'b11, 1, T2, 0, 0, 0, 2'b00, 0, 0, 0, "R3 pending at T2");
    tick(2'b11, 1, T3, 0, 0, 0, 2'b00, 0, 0, 0, "R3 pending at T3");
    tick(2'b11, 1, T4, 0, 0, 0, 2'b01, 0, 1, 0, "R3 grant after T4");
    tick(2'b11, 0, T1, 0, 0, 0, 2'b00, 1, 1, 0, "R2 hold after grant");
    tick(2'b10, 0, T1, 0, 0, 0, 2'b00, 0, 1, 0, "R11 stall in dead");
    tick(2'b11, 0, T1, 0, 0, 0, 2'b00, 0, 0, 0, "R11 stall clear");

    // late request on line 1
    tick(2'b01, 1, T3, 0, 0, 0, 2'b00, 0, 0, 0, "R4 late pending");
    tick(2'b11, 1, T4, 0, 0, 0, 2'b00, 0, 0, 0, "R4 same T4 skipped");
    tick(2'b11, 1, T1, 0, 0, 0, 2'b00, 0, 0, 0, "R4 pending");
    tick(2'b11, 1, T2, 0, 0, 0, 2'b00, 0, 0, 0, "R4 pending");
    tick(2'b11, 1, T3, 0, 0, 0, 2'b00, 0, 0, 0, "R4 pending");
    tick(2'b11, 1, T4, 0, 0, 0, 2'b10, 0, 1, 0, "R4 next T4 grant");
    tick(2'b11, 0, T1, 0, 0, 0, 2'b00, 1, 1, 0, "R4 hold");
    tick(2'b10, 0, T1, 0, 0, 0, 2'b00, 1, 1, 1, "R10 other line in hold");
    tick(2'b01, 0, T1, 0, 0, 0, 2'b00, 0, 1, 0, "R7 release line 1");
    tick(2'b11, 0, T1, 0, 0, 0, 2'b00, 0, 0, 0, "R7 idle");

    // split word then interrupt acknowledge
    tick(2'b10, 1, T1, 0, 0, 0, 2'b00, 0, 0, 0, "R5 pending");
    tick(2'b01, 1, T2, 1, 0, 0, 2'b00, 0, 0, 1, "R10 pulse while pending");
    tick(2'b11, 1, T3, 1, 0, 0, 2'b00, 0, 0, 0, "R5 pending");
    tick(2'b11, 1, T4, 1, 0, 0, 2'b00, 0, 0, 0, "R5 split blocks");
    tick(2'b11, 1, T1, 0, 1, 0, 2'b00, 0, 0, 0, "R5 pending");
    tick(2'b11, 1, T2, 0, 1, 0, 2'b00, 0, 0, 0, "R5 pending");
    tick(2'b11, 1, T3, 0, 1, 0, 2'b00, 0, 0, 0, "R5 pending");
    tick(2'b11, 1, T4, 0, 1, 0, 2'b00, 0, 0, 0, "R5 inta blocks");
    tick(2'b11, 1, T1, 0, 0, 0, 2'b00, 0, 0, 0, "R5 pending");
    tick(2'b11, 1, T2, 0, 0, 0, 2'b00, 0, 0, 0, "R5 pending");
    tick(2'b11, 1, T3, 0, 0, 0, 2'b00, 0, 0, 0, "R5 pending");
    tick(2'b11, 1, T4, 0, 0, 0, 2'b01, 0, 1, 0, "R5 clean T4 grant");
    tick(2'b11, 0, T1, 0, 0, 0, 2'b00, 1, 1, 0, "R5 hold");
    tick(2'b10, 0, T1, 0, 0, 0, 2'b00, 0, 1, 0, "R7 release");
    tick(2'b11, 0, T1, 0, 0, 0, 2'b00, 0, 0, 0, "R7 idle");

    // lock on line 1 request
    tick(2'b01, 0, T1, 0, 0, 1, 2'b00, 0, 0, 0, "R6 idle lock blocks");
    tick(2'b11, 0, T1, 0, 0, 1, 2'b00, 0, 0, 0, "R6 still blocked");
    tick(2'b11, 1, T4, 0, 0, 1, 2'b00, 0, 0, 0, "R6 T4 lock blocks");
    tick(2'b11, 0, T1, 0, 0, 0, 2'b10, 0, 1, 0, "R6 grant after unlock");
    tick(2'b11, 0, T1, 0, 0, 0, 2'b00, 1, 1, 0, "R6 hold");
    tick(2'b01, 0, T1, 0, 0, 0, 2'b00, 0, 1, 0, "R7 release");
    tick(2'b11, 0, T1, 0, 0, 0, 2'b00, 0, 0, 0, "R7 idle");

    // simultaneous requests
    tick(2'b00, 0, T1, 0, 0, 0, 2'b01, 0, 1, 0, "R8 line 0 wins");
    tick(2'b11, 0, T1, 0, 0, 0, 2'b00, 1, 1, 0, "R8 hold");
    tick(2'b01, 0, T1, 0, 0, 0, 2'b00, 1, 1, 1, "R8 line 1 not owner");
    tick(2'b10, 0, T1, 0, 0, 0, 2'b00, 0, 1, 0, "R8 release line 0");
    tick(2'b11, 0, T1, 0, 0, 0, 2'b00, 0, 0, 0, "R8 idle");

    repeat (3) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule